// File: doc/BRIEF.md
# Coprocessor Control and Status Register Block

This block is the host-facing register set of a small data-transfer coprocessor. A host CPU writes an 8-bit control register to enable event interrupts, to open the coprocessor program RAM for loading, to hand an entry address to the coprocessor, and to start or stop it. An 8-bit status register holds two event flags that the coprocessor raises with single-cycle pulses. A write-only pointer register holds the entry address.

The block enforces a mutual lock between program loading and running. A stop event halts the coprocessor in hardware, and reading the status register acknowledges the flags. The block drives one shared interrupt request, which the CPU global mask gates. It also drives a wake signal that leaves wait mode whenever an enabled event is pending.

Register map on `bus_addr`: 0 is control, 1 is status, 2 is the pointer (write-only), and 3 is unused. Reads return `bus_rdata` combinationally in the same cycle. Writes take effect at the clock edge.

Top module: `xfer_cop_regs`

## Requirements
- R1: After reset, the control, status and pointer registers are all 00h. The run, interrupt, wake, RAM-write and program-counter outputs are low.
- R2: Control layout: bit 4 is the error interrupt enable, bit 3 the stop interrupt enable, bit 2 load, bit 1 init and bit 0 run. Bits 7:5 always read 0, and writing them has no effect.
- R3: A write that sets load is refused while run is 1. A write that sets run is refused while load is 1. If one write from idle asks for both, load is taken and run is refused.
- R4: A stop event pulse clears run at the same clock edge that sets the stop flag. This overrides a host write of run in that cycle.
- R5: Status layout: bit 1 is the error flag and bit 0 the stop flag. Bits 7:2 always read 0.
- R6: An event pulse sets its flag at the next edge. A read of address 1 returns the current flags and clears both at the end of the read cycle.
- R7: An event pulse in the same cycle as a clearing status read wins, so that flag stays set.
- R8: Address 2 stores an 8-bit pointer and reads back as 00h, and address 3 also reads 00h. The program-counter output equals the pointer while init is 1 and is 00h otherwise. The load-pc output equals init.
- R9: `ram_wr_out` follows `ram_wr_in` only while load is 1, and is 0 otherwise.
- R10: `irq` equals ((error flag AND error enable) OR (stop flag AND stop enable)) AND NOT `cpu_imask`.
- R11: `wake` is high whenever an enabled event flag is set, regardless of `cpu_imask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a status read clears the flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| evt_err | input | 1 | Error event pulse from the coprocessor |
| evt_stop | input | 1 | Stop event pulse from the coprocessor |
| cpu_imask | input | 1 | CPU global interrupt mask, 1 = masked |
| ram_wr_in | input | 1 | Host program-RAM write strobe |
| ram_wr_out | output | 1 | Gated program-RAM write strobe |
| pc_o | output | 8 | Entry address to the coprocessor program counter |
| pc_load_o | output | 1 | Program counter load request (init bit) |
| run_o | output | 1 | Coprocessor run enable |
| irq | output | 1 | Shared interrupt request |
| wake | output | 1 | Wake-from-wait request |

## Verification
The bench targets several corner cases:
- **Load and run requested in one write.** A design that checks only the old register value would end with both bits set at once.
- **Stop event while the host rewrites run.** A design that lets the host write win would leave the coprocessor running after it has stopped.
- **Event pulse during a clearing read.** Here the flag must survive, or the event is silently lost.
- **Masked interrupt.** `irq` must drop while `wake` stays high, which catches a design that gates the wrong output with the mask.
- **Reads of the pointer address and of reserved bits.** These must return zeros, which exposes a design that leaks stored pointer data onto the bus.

// File: rtl/cop_regs_pkg.sv
package cop_regs_pkg;

  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_PTR  = 2;

  localparam int FLAG_STOP = 0;
  localparam int FLAG_ERR  = 1;
  localparam int N_EVT     = 2;
  localparam int CTRL_W    = 5;

  typedef struct packed {
    logic err_en;
    logic stop_en;
    logic load;
    logic init;
    logic run;
  } ctrl_t;

  // Next control value for a host write, applying the load/run lock.
  function automatic ctrl_t ctrl_after_write(ctrl_t cur, logic [CTRL_W-1:0] wd);
    ctrl_t n;
    n      = ctrl_t'(wd);
    n.load = wd[2] & ~cur.run;
    n.run  = wd[0] & ~cur.load & ~n.load;
    return n;
  endfunction

  // Any enabled event flag pending.
  function automatic logic event_pending(logic [N_EVT-1:0] flg, ctrl_t c);
    return (flg[FLAG_ERR] & c.err_en) | (flg[FLAG_STOP] & c.stop_en);
  endfunction

endpackage

// File: rtl/cop_ctrl_reg.sv
module cop_ctrl_reg
  import cop_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_ptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stop_hw_clr,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] ptr_q
);

  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_after_write(ctrl_q, wdata[CTRL_W-1:0]);
    if (stop_hw_clr) ctrl_d.run = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ptr_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_ptr) ptr_q <= wdata;
    end
  end

endmodule

// File: rtl/cop_status_flags.sv
module cop_status_flags #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] evt,
  input  logic           rd_clr,
  output logic [NUM-1:0] flags
);

  for (genvar i = 0; i < NUM; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= evt[i] | (q & ~rd_clr);
    end
    assign flags[i] = q;
  end

endmodule

// File: rtl/cop_irq_out.sv
module cop_irq_out
  import cop_regs_pkg::*;
(
  input  logic [N_EVT-1:0] flags,
  input  ctrl_t            ctrl,
  input  logic             cpu_imask,
  output logic             irq,
  output logic             wake
);

  logic pend;

  assign pend = event_pending(flags, ctrl);
  assign irq  = pend & ~cpu_imask;
  assign wake = pend;

endmodule

// File: rtl/xfer_cop_regs.sv
module xfer_cop_regs
  import cop_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_err,
  input  logic              evt_stop,
  input  logic              cpu_imask,
  input  logic              ram_wr_in,
  output logic              ram_wr_out,
  output logic [DATA_W-1:0] pc_o,
  output logic              pc_load_o,
  output logic              run_o,
  output logic              irq,
  output logic              wake
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(REG_PTR);

  logic              wr_ctrl, wr_ptr, rd_stat;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] ptr_q;
  logic [N_EVT-1:0]  evt_vec, flags;

  assign wr_ctrl = bus_wr & (bus_addr == A_CTRL);
  assign wr_ptr  = bus_wr & (bus_addr == A_PTR);
  assign rd_stat = bus_rd & (bus_addr == A_STAT);

  always_comb begin
    evt_vec            = '0;
    evt_vec[FLAG_ERR]  = evt_err;
    evt_vec[FLAG_STOP] = evt_stop;
  end

  cop_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_ptr(wr_ptr),
    .wdata(bus_wdata), .stop_hw_clr(evt_stop), .ctrl_q(ctrl_q), .ptr_q(ptr_q)
  );

  cop_status_flags #(.NUM(N_EVT)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .rd_clr(rd_stat), .flags(flags)
  );

  cop_irq_out u_irq (
    .flags(flags), .ctrl(ctrl_q), .cpu_imask(cpu_imask), .irq(irq), .wake(wake)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      A_STAT:  bus_rdata = DATA_W'(flags);
      default: bus_rdata = '0;
    endcase
  end

  assign ram_wr_out = ram_wr_in & ctrl_q.load;
  assign pc_load_o  = ctrl_q.init;
  assign pc_o       = ctrl_q.init ? ptr_q : '0;
  assign run_o      = ctrl_q.run;

endmodule

// File: rtl/xfer_cop_regs_chk.sv
module xfer_cop_regs_chk
  import cop_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              evt_err,
  input logic              evt_stop,
  input logic              rd_stat,
  input logic [N_EVT-1:0]  flags,
  input ctrl_t             ctrl_q,
  input logic              cpu_imask,
  input logic              ram_wr_out,
  input logic              irq,
  input logic              wake
);

  p_load_run_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q.load && ctrl_q.run));

  p_stop_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !ctrl_q.run);

  p_err_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> flags[FLAG_ERR]);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !evt_err) |=> !flags[FLAG_ERR]);

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && evt_stop) |=> flags[FLAG_STOP]);

  p_ram_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.load |-> !ram_wr_out);

  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_imask |-> !irq);

  p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);

  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(REG_CTRL)) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0));

  p_ptr_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(REG_PTR)) |-> (bus_rdata == '0));

endmodule

bind xfer_cop_regs xfer_cop_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .evt_err(evt_err), .evt_stop(evt_stop), .rd_stat(rd_stat), .flags(flags),
  .ctrl_q(ctrl_q), .cpu_imask(cpu_imask), .ram_wr_out(ram_wr_out),
  .irq(irq), .wake(wake)
);

// File: tb/tb_xfer_cop_regs.sv
`timescale 1ns/1ps
module tb_xfer_cop_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       evt_err = 1'b0, evt_stop = 1'b0, cpu_imask = 1'b0, ram_wr_in = 1'b0;
  logic       ram_wr_out, pc_load_o, run_o, irq, wake;
  logic [7:0] pc_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  xfer_cop_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_err(evt_err), .evt_stop(evt_stop),
    .cpu_imask(cpu_imask), .ram_wr_in(ram_wr_in), .ram_wr_out(ram_wr_out), .pc_o(pc_o),
    .pc_load_o(pc_load_o), .run_o(run_o), .irq(irq), .wake(wake)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(logic e, logic s);
    @(negedge clk);
    evt_err = e; evt_stop = s;
    @(negedge clk);
    evt_err = 1'b0; evt_stop = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 ctrl reset", d, 8'h00);
    rd(2'd1, d); chk("R1 status reset", d, 8'h00);
    chk("R1 outputs low", {3'b0, run_o, irq, wake, ram_wr_out, pc_load_o}, 8'h00);
    chk("R1 pc reset", pc_o, 8'h00);
  endtask

  task automatic t_ctrl_layout();
    logic [7:0] d;
    wr(2'd0, 8'hFF); rd(2'd0, d);
    chk("R2/R3 all-ones write: rsvd 0, load taken, run refused", d, 8'h1E);
    wr(2'd0, 8'h00); rd(2'd0, d); chk("R2 clear", d, 8'h00);
    wr(2'd0, 8'hF9); rd(2'd0, d); chk("R2 enables+run", d, 8'h19);
    chk("R2 run_o", {7'b0, run_o}, 8'h01);
  endtask

  task automatic t_interlock();
    logic [7:0] d;
    wr(2'd0, 8'h1D); rd(2'd0, d); chk("R3 load refused while run", d, 8'h19);
    wr(2'd0, 8'h00); wr(2'd0, 8'h04); rd(2'd0, d); chk("R3 load set", d, 8'h04);
    wr(2'd0, 8'h05); rd(2'd0, d); chk("R3 run refused while load", d, 8'h04);
    wr(2'd0, 8'h01); rd(2'd0, d); chk("R3 run refused, load dropped", d, 8'h00);
  endtask

  task automatic t_ram_gate();
    @(negedge clk); ram_wr_in = 1'b1;
    #1 chk("R9 strobe blocked", {7'b0, ram_wr_out}, 8'h00);
    wr(2'd0, 8'h04);
    #1 chk("R9 strobe passed", {7'b0, ram_wr_out}, 8'h01);
    ram_wr_in = 1'b0;
    #1 chk("R9 strobe follows", {7'b0, ram_wr_out}, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    pulse(1'b1, 1'b0); rd(2'd1, d); chk("R5/R6 error flag", d, 8'h02);
    rd(2'd1, d); chk("R6 cleared by read", d, 8'h00);
    pulse(1'b0, 1'b1); rd(2'd1, d); chk("R5/R6 stop flag", d, 8'h01);
    rd(2'd1, d); chk("R6 stop cleared", d, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1; evt_err = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; evt_err = 1'b0;
    rd(2'd1, d); chk("R7 event survives read", d, 8'h02);
    rd(2'd1, d); chk("R7 later read clears", d, 8'h00);
    pulse(1'b0, 1'b1);
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1; evt_stop = 1'b1;
    #1 d = bus_rdata; chk("R6 read returns pre-clear value", d, 8'h01);
    @(negedge clk);
    bus_rd = 1'b0; evt_stop = 1'b0;
    rd(2'd1, d); chk("R7 set flag re-hit survives", d, 8'h01);
  endtask

  task automatic t_stop_run();
    logic [7:0] d;
    wr(2'd0, 8'h01); chk("R4 running", {7'b0, run_o}, 8'h01);
    pulse(1'b0, 1'b1);
    chk("R4 stop clears run", {7'b0, run_o}, 8'h00);
    rd(2'd0, d); chk("R4 ctrl after stop", d, 8'h00);
    wr(2'd0, 8'h01);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h01; bus_wr = 1'b1; evt_stop = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; evt_stop = 1'b0;
    chk("R4 stop overrides host run write", {7'b0, run_o}, 8'h00);
    rd(2'd1, d);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    wr(2'd2, 8'hA5);
    chk("R8 pc hidden while init 0", pc_o, 8'h00);
    rd(2'd2, d); chk("R8 pointer reads 00h", d, 8'h00);
    wr(2'd0, 8'h02);
    chk("R8 pc follows pointer", pc_o, 8'hA5);
    chk("R8 pc_load", {7'b0, pc_load_o}, 8'h01);
    wr(2'd2, 8'h3C); chk("R8 pc tracks new pointer", pc_o, 8'h3C);
    rd(2'd3, d); chk("R8 unused address reads 00h", d, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(2'd0, 8'h10);
    pulse(1'b0, 1'b1);
    chk("R10 disabled stop no irq", {6'b0, irq, wake}, 8'h00);
    rd(2'd1, d);
    pulse(1'b1, 1'b0);
    chk("R10/R11 enabled error", {6'b0, irq, wake}, 8'h03);
    @(negedge clk); cpu_imask = 1'b1;
    #1 chk("R10/R11 masked irq, wake stays", {6'b0, irq, wake}, 8'h01);
    cpu_imask = 1'b0;
    rd(2'd1, d);
    chk("R10 read drops irq", {6'b0, irq, wake}, 8'h00);
    wr(2'd0, 8'h08);
    pulse(1'b0, 1'b1);
    chk("R10 enabled stop", {6'b0, irq, wake}, 8'h03);
    rd(2'd1, d);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_layout();
    t_interlock();
    t_ram_gate();
    t_flags();
    t_collision();
    t_stop_run();
    t_pointer();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule